// File: doc/BRIEF.md
# Low-Power Mode Sequencer for LPDDR Memory

This block moves an LPDDR memory into and out of three reduced-power modes: self refresh, power down and deep power down. The user side issues entry and exit requests in pairs. The block drives the clock-enable line and issues a one-cycle entry command on the memory command bus. It can stop the memory clock while the memory is resident in self refresh or power down. It then brings the clock back ahead of clock-enable on exit.

Leaving self refresh or power down ends with a recovery wait. The length of that wait depends on the mode. Leaving deep power down instead hands control to an external initialisation sequencer through a request/done handshake. After initialisation, the block can also hand control to an I/O retrain engine. A request that does not fit the current state is dropped and reported with a one-cycle error pulse.

Top module: `lp_mode_seq`

## Requirements
- R1: Out of reset, cke_o and mclk_en_o are 1 and mem_cmd_o is 0 (NOP). busy_o, done_o, err_o, init_req_o and retrain_req_o are 0, and mode_o is 0.
- R2: Request codes on req_cmd_i are 0/1 for self refresh enter/exit, 2/3 for power down enter/exit and 4/5 for deep power down enter/exit. Codes 6 and 7 are reserved.
- R3: A legal entry sampled while idle produces the following. In the next cycle, mem_cmd_o carries the entry code (1 self refresh, 2 power down, 3 deep power down) for exactly one cycle, with cke_o low and busy_o high. cke_o then stays low and busy_o stays high for T_CKE_MIN further cycles, after which busy_o drops with the memory resident.
- R4: mclk_en_o stays high through the entry command and the T_CKE_MIN hold cycles.
- R5: While resident in self refresh or power down with cfg_clk_stop_i set, mclk_en_o is 0. It stays 1 when cfg_clk_stop_i is clear, and it is never 0 in deep power down.
- R6: A matching exit raises mclk_en_o in the next cycle. cke_o is held low for T_CLK_LEAD cycles with the clock running before it rises.
- R7: After a self refresh exit, busy_o stays high for T_XSR cycles from the cke_o rise. Then done_o pulses for one cycle with busy_o low and mode_o 0.
- R8: After a power down exit, the recovery wait before the done_o pulse is T_XP cycles.
- R9: On a deep power down exit, init_req_o is held high with cke_o high from the cke_o rise until init_done_i is sampled high.
- R10: After initialisation completes, if cfg_retrain_en_i is set, retrain_req_o is held high until retrain_done_i is sampled high, and then done_o pulses. With retraining disabled, done_o pulses directly.
- R11: The following requests are ignored: an exit while idle, an exit for a mode other than the resident one, an entry while resident, any request while busy, and a reserved code. Each raises err_o for one cycle after the request, and leaves mode_o, cke_o and busy_o unchanged.
- R12: mode_o reports 0 none, 1 self refresh, 2 power down, 3 deep power down. It holds that value from the entry command until the cycle done_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_cmd_i | input | 3 | Request code |
| cfg_clk_stop_i | input | 1 | Stop the memory clock while resident in self refresh or power down |
| cfg_retrain_en_i | input | 1 | Run an I/O retrain after deep power down initialisation |
| init_done_i | input | 1 | Initialisation sequencer finished |
| retrain_done_i | input | 1 | Retrain engine finished |
| busy_o | output | 1 | Entry or exit sequence in progress |
| done_o | output | 1 | One-cycle pulse when an exit sequence completes |
| err_o | output | 1 | One-cycle pulse for an ignored request |
| mode_o | output | 2 | Current low-power mode |
| cke_o | output | 1 | Memory clock enable |
| mclk_en_o | output | 1 | Memory clock gate enable |
| mem_cmd_o | output | 2 | Memory command, 0 NOP, otherwise the entry code |
| init_req_o | output | 1 | Request full memory initialisation |
| retrain_req_o | output | 1 | Request I/O retrain |

## Verification
Several rules are checked on every cycle. The memory clock may only be stopped in self refresh or power down, with the option set and clock-enable low. It must follow at least T_CKE_MIN cycles of clock-enable low. Clock-enable may only rise after at least T_CLK_LEAD cycles of running clock. An entry command never appears with clock-enable high, and initialisation and retrain requests appear only during a deep power down exit. Error pulses follow request strobes, and done coincides with idle. The exact recovery lengths T_XSR and T_XP, the dropping of each kind of illegal request with state intact, and the handshake order with and without retraining can only be shown by the bench's directed scenarios.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  typedef enum logic [1:0] {
    LPM_NONE = 2'd0,
    LPM_SREF = 2'd1,
    LPM_PDN  = 2'd2,
    LPM_DPD  = 2'd3
  } lp_mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ENTER, S_HOLD, S_RES, S_WAKE, S_XWAIT, S_INIT, S_TRAIN
  } seq_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lp_req_decode.sv
module lp_req_decode
  import lp_seq_pkg::*;
(
  input  logic       req_valid_i,
  input  logic [2:0] req_cmd_i,
  input  logic       idle_i,
  input  logic       resident_i,
  input  lp_mode_e   cur_mode_i,
  output logic       enter_o,
  output logic       exit_o,
  output lp_mode_e   req_mode_o,
  output logic       bad_o
);
  logic [1:0] kind;
  logic       is_exit;
  logic       reserved;

  always_comb begin
    kind       = req_cmd_i[2:1];
    is_exit    = req_cmd_i[0];
    reserved   = (kind == 2'b11);
    req_mode_o = lp_mode_e'(kind + 2'd1);
    enter_o    = req_valid_i && !reserved && !is_exit && idle_i;
    exit_o     = req_valid_i && !reserved && is_exit && resident_i &&
                 (req_mode_o == cur_mode_i);
    bad_o      = req_valid_i && !enter_o && !exit_o;
  end
endmodule

// File: rtl/lp_delay_cnt.sv
module lp_delay_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lp_mode_seq.sv
module lp_mode_seq
  import lp_seq_pkg::*;
#(
  parameter int T_CKE_MIN  = 3,
  parameter int T_CLK_LEAD = 2,
  parameter int T_XSR      = 10,
  parameter int T_XP       = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [2:0] req_cmd_i,
  input  logic       cfg_clk_stop_i,
  input  logic       cfg_retrain_en_i,
  input  logic       init_done_i,
  input  logic       retrain_done_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [1:0] mode_o,
  output logic       cke_o,
  output logic       mclk_en_o,
  output logic [1:0] mem_cmd_o,
  output logic       init_req_o,
  output logic       retrain_req_o
);
  localparam int T_MAX = max2(max2(T_CKE_MIN, T_CLK_LEAD), max2(T_XSR, T_XP));
  localparam int CW    = $clog2(T_MAX + 1);

  localparam logic [CW-1:0] LD_HOLD = CW'(T_CKE_MIN - 1);
  localparam logic [CW-1:0] LD_LEAD = CW'(T_CLK_LEAD - 1);
  localparam logic [CW-1:0] LD_XSR  = CW'(T_XSR - 1);
  localparam logic [CW-1:0] LD_XP   = CW'(T_XP - 1);

  seq_state_e state_q, state_d;
  lp_mode_e   mode_q, mode_d;
  logic       done_q, done_d;
  logic       err_q;

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;

  logic     dec_enter, dec_exit, dec_bad;
  lp_mode_e dec_mode;

  lp_req_decode u_dec (
    .req_valid_i (req_valid_i),
    .req_cmd_i   (req_cmd_i),
    .idle_i      (state_q == S_IDLE),
    .resident_i  (state_q == S_RES),
    .cur_mode_i  (mode_q),
    .enter_o     (dec_enter),
    .exit_o      (dec_exit),
    .req_mode_o  (dec_mode),
    .bad_o       (dec_bad)
  );

  lp_delay_cnt #(.W(CW)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      S_IDLE: if (dec_enter) begin
        state_d = S_ENTER;
        mode_d  = dec_mode;
      end
      S_ENTER: begin
        state_d  = S_HOLD;
        tmr_load = 1'b1;
        tmr_val  = LD_HOLD;
      end
      S_HOLD: if (tmr_zero) state_d = S_RES;
      S_RES: if (dec_exit) begin
        state_d  = S_WAKE;
        tmr_load = 1'b1;
        tmr_val  = LD_LEAD;
      end
      S_WAKE: if (tmr_zero) begin
        if (mode_q == LPM_DPD) begin
          state_d = S_INIT;
        end else begin
          state_d  = S_XWAIT;
          tmr_load = 1'b1;
          tmr_val  = (mode_q == LPM_SREF) ? LD_XSR : LD_XP;
        end
      end
      S_XWAIT: if (tmr_zero) begin
        state_d = S_IDLE;
        mode_d  = LPM_NONE;
        done_d  = 1'b1;
      end
      S_INIT: if (init_done_i) begin
        if (cfg_retrain_en_i) begin
          state_d = S_TRAIN;
        end else begin
          state_d = S_IDLE;
          mode_d  = LPM_NONE;
          done_d  = 1'b1;
        end
      end
      S_TRAIN: if (retrain_done_i) begin
        state_d = S_IDLE;
        mode_d  = LPM_NONE;
        done_d  = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      mode_q  <= LPM_NONE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      done_q  <= done_d;
      err_q   <= dec_bad;
    end
  end

  // cke high only outside the low-power window
  assign cke_o         = (state_q == S_IDLE) || (state_q == S_XWAIT) ||
                         (state_q == S_INIT) || (state_q == S_TRAIN);
  assign mclk_en_o     = !((state_q == S_RES) && cfg_clk_stop_i && (mode_q != LPM_DPD));
  assign mem_cmd_o     = (state_q == S_ENTER) ? mode_q : LPM_NONE;
  assign busy_o        = (state_q != S_IDLE) && (state_q != S_RES);
  assign init_req_o    = (state_q == S_INIT);
  assign retrain_req_o = (state_q == S_TRAIN);
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign mode_o        = mode_q;
endmodule

// File: rtl/lp_mode_seq_chk.sv
module lp_mode_seq_chk #(
  parameter int T_CKE_MIN  = 3,
  parameter int T_CLK_LEAD = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       cfg_clk_stop_i,
  input logic       init_done_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic [1:0] mode_o,
  input logic       cke_o,
  input logic       mclk_en_o,
  input logic [1:0] mem_cmd_o,
  input logic       init_req_o,
  input logic       retrain_req_o
);
  logic [15:0] cke_low_cnt, clk_on_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_low_cnt <= '0;
      clk_on_cnt  <= '0;
    end else begin
      cke_low_cnt <= cke_o ? '0 : ((cke_low_cnt == '1) ? cke_low_cnt : cke_low_cnt + 1'b1);
      clk_on_cnt  <= !mclk_en_o ? '0 : ((clk_on_cnt == '1) ? clk_on_cnt : clk_on_cnt + 1'b1);
    end
  end

  AST_GATE_AFTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mclk_en_o) |-> cke_low_cnt >= 16'(T_CKE_MIN)); // R4

  AST_GATE_ONLY_SR_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mclk_en_o |-> (cfg_clk_stop_i && !cke_o && (mode_o == 2'd1 || mode_o == 2'd2))); // R5

  AST_CLK_LEADS_CKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> clk_on_cnt >= 16'(T_CLK_LEAD)); // R6

  AST_CMD_WITH_CKE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cmd_o != 2'd0) |-> (!cke_o && busy_o && mem_cmd_o == mode_o)); // R3

  AST_INIT_ONLY_DPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_req_o |-> (mode_o == 2'd3 && cke_o && !retrain_req_o)); // R9

  AST_RETRAIN_AFTER_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(retrain_req_o) |-> ($past(init_req_o) && $past(init_done_i))); // R10

  AST_ERR_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_valid_i)); // R11

  AST_DONE_AT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && cke_o && mode_o == 2'd0)); // R7

  AST_RESIDENT_CKE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd0 && !busy_o && !done_o) |-> !cke_o); // R12
endmodule

bind lp_mode_seq lp_mode_seq_chk #(
  .T_CKE_MIN  (T_CKE_MIN),
  .T_CLK_LEAD (T_CLK_LEAD)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .cfg_clk_stop_i (cfg_clk_stop_i),
  .init_done_i    (init_done_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .err_o          (err_o),
  .mode_o         (mode_o),
  .cke_o          (cke_o),
  .mclk_en_o      (mclk_en_o),
  .mem_cmd_o      (mem_cmd_o),
  .init_req_o     (init_req_o),
  .retrain_req_o  (retrain_req_o)
);

// File: tb/lp_mode_seq_tb_top.sv
module lp_mode_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T_CKE_MIN  = 3;
  localparam int T_CLK_LEAD = 2;
  localparam int T_XSR      = 10;
  localparam int T_XP       = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_cmd = 3'd0;
  logic       cfg_stop = 1'b0;
  logic       cfg_retrain = 1'b0;
  logic       init_done = 1'b0;
  logic       retrain_done = 1'b0;
  logic       busy, done, err, cke, mclk_en, init_req, retrain_req;
  logic [1:0] mode, mem_cmd;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_mode_seq #(
    .T_CKE_MIN(T_CKE_MIN), .T_CLK_LEAD(T_CLK_LEAD), .T_XSR(T_XSR), .T_XP(T_XP)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_cmd_i(req_cmd),
    .cfg_clk_stop_i(cfg_stop), .cfg_retrain_en_i(cfg_retrain),
    .init_done_i(init_done), .retrain_done_i(retrain_done),
    .busy_o(busy), .done_o(done), .err_o(err), .mode_o(mode), .cke_o(cke),
    .mclk_en_o(mclk_en), .mem_cmd_o(mem_cmd), .init_req_o(init_req),
    .retrain_req_o(retrain_req)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive for one cycle; returns in the cycle after the sampling edge
  task automatic send(input logic [2:0] code);
    req_valid = 1'b1;
    req_cmd   = code;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(cke, 1, "R1 cke");
    chk(mclk_en, 1, "R1 mclk_en");
    chk(mem_cmd, 0, "R1 mem_cmd");
    chk(busy, 0, "R1 busy");
    chk(done, 0, "R1 done");
    chk(err, 0, "R1 err");
    chk(mode, 0, "R1 mode");
    chk(init_req | retrain_req, 0, "R1 handshakes");
  endtask

  task automatic t_enter(input logic [2:0] code, input logic [1:0] m);
    send(code);
    chk(mem_cmd, m, "R3 R2 entry command");
    chk(cke, 0, "R3 cke low at entry");
    chk(busy, 1, "R3 busy at entry");
    chk(mode, m, "R12 mode at entry");
    chk(mclk_en, 1, "R4 clock on at entry");
    for (int i = 0; i < T_CKE_MIN; i++) begin
      tick(1);
      chk(mem_cmd, 0, "R3 command one cycle");
      chk(cke, 0, "R3 cke held low");
      chk(busy, 1, "R3 busy in hold");
      chk(mclk_en, 1, "R4 clock on in hold");
    end
    tick(1);
    chk(busy, 0, "R3 resident not busy");
    chk(cke, 0, "R3 resident cke low");
    chk(mclk_en, !(cfg_stop && m != 2'd3), "R5 clock gate when resident");
    tick(3);
    chk(mclk_en, !(cfg_stop && m != 2'd3), "R5 gate steady");
    chk(mode, m, "R12 mode resident");
  endtask

  task automatic t_exit_timed(input logic [2:0] code, input int trec, input string tag);
    send(code);
    chk(mclk_en, 1, "R6 clock back at exit");
    chk(cke, 0, "R6 cke low at wake");
    chk(busy, 1, "R6 busy at wake");
    for (int i = 1; i < T_CLK_LEAD; i++) begin
      tick(1);
      chk(cke, 0, "R6 cke low during lead");
    end
    tick(1);
    for (int i = 0; i < trec; i++) begin
      chk(cke, 1, {tag, " cke high in recovery"});
      chk(busy, 1, {tag, " busy in recovery"});
      chk(done, 0, {tag, " no early done"});
      tick(1);
    end
    chk(done, 1, {tag, " done pulse"});
    chk(busy, 0, {tag, " idle at done"});
    chk(mode, 0, "R12 mode cleared");
    tick(1);
    chk(done, 0, {tag, " done one cycle"});
  endtask

  task automatic t_dpd(input logic retrain);
    cfg_retrain = retrain;
    t_enter(3'd4, 2'd3);
    send(3'd5);
    chk(cke, 0, "R6 dpd cke low at wake");
    tick(T_CLK_LEAD);
    chk(cke, 1, "R9 cke high for init");
    chk(init_req, 1, "R9 init request");
    tick(3);
    chk(init_req, 1, "R9 init held");
    chk(done, 0, "R9 no done while init");
    init_done = 1'b1;
    tick(1);
    init_done = 1'b0;
    chk(init_req, 0, "R9 init dropped");
    if (retrain) begin
      chk(retrain_req, 1, "R10 retrain request");
      chk(done, 0, "R10 no done before retrain");
      tick(2);
      chk(retrain_req, 1, "R10 retrain held");
      retrain_done = 1'b1;
      tick(1);
      retrain_done = 1'b0;
      chk(retrain_req, 0, "R10 retrain dropped");
    end else begin
      chk(retrain_req, 0, "R10 retrain skipped");
    end
    chk(done, 1, "R10 done after dpd exit");
    chk(mode, 0, "R12 mode cleared after dpd");
    tick(1);
  endtask

  task automatic t_errors();
    send(3'd1);
    chk(err, 1, "R11 exit while idle flagged");
    chk(mode, 0, "R11 mode kept idle");
    chk(cke, 1, "R11 cke kept idle");
    tick(1);
    chk(err, 0, "R11 err one cycle");
    send(3'd6);
    chk(err, 1, "R11 R2 reserved code flagged");
    chk(busy, 0, "R11 reserved no start");
    send(3'd2);
    send(3'd0);
    chk(err, 1, "R11 request while busy flagged");
    chk(mode, 2, "R11 mode kept while busy");
    tick(T_CKE_MIN);
    chk(busy, 0, "R11 entry completed");
    send(3'd0);
    chk(err, 1, "R11 entry while resident flagged");
    chk(mode, 2, "R11 mode kept resident");
    chk(cke, 0, "R11 cke kept resident");
    send(3'd1);
    chk(err, 1, "R11 mismatched exit flagged");
    chk(busy, 0, "R11 mismatched exit no start");
    send(3'd5);
    chk(err, 1, "R11 mismatched dpd exit flagged");
    tick(1);
    chk(err, 0, "R11 err cleared");
    t_exit_timed(3'd3, T_XP, "R8");
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    cfg_stop = 1'b1;
    t_enter(3'd0, 2'd1);
    t_exit_timed(3'd1, T_XSR, "R7");
    cfg_stop = 1'b0;
    t_enter(3'd2, 2'd2);
    t_exit_timed(3'd3, T_XP, "R8");
    cfg_stop = 1'b1;
    t_enter(3'd2, 2'd2);
    t_exit_timed(3'd3, T_XP, "R8");
    t_dpd(1'b1);
    t_dpd(1'b0);
    cfg_stop = 1'b0;
    t_errors();
    tick(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule